// File: doc/BRIEF.md
# Display Timing Fault Monitor

This block runs on the pixel clock next to a video receiver and decides whether the recovered sync timing is steady from one line and one frame to the next. It measures how long each data-enable active window lasts and how long each vertical sync period lasts. It compares every measurement with the one that came just before it. It then drives a single status output, high when timing is sound and low once a fault has been seen.

A data-enable length that changes even once counts as a fault. The vertical period is allowed one stray change, and a fault is raised only after two changes in a row. A latched fault holds the status low until reset, until the power-down input is driven low, or until the clear strobe is pulsed. While self-test is enabled, the same output reports the self-test error input instead of the timing state.

Top module: `stm_timing_monitor`

## Requirements
- R1: After reset, with self-test disabled and no fault seen, `timing_ok` is 1.
- R2: A data-enable active length that differs from the previous one sets the fault, and `timing_ok` goes to 0 within three clocks of the data-enable falling edge.
- R3: A vertical period that differs from the previous one raises a fault only if the period before it also differed; a single differing period leaves `timing_ok` at 1.
- R4: A vertical period equal to the previous one resets the consecutive-mismatch count to zero, so two mismatches separated by a match raise no fault.
- R5: After reset or power-down, the first measurement of each kind only becomes the reference and cannot raise a fault.
- R6: Once set, the fault stays latched until reset, power-down or a one-clock `flag_clear` pulse. A new fault detected in the same clock as the clear wins over the clear.
- R7: While `self_test_en` is 1, `timing_ok` equals the inverse of `self_test_err`, whatever the timing state.
- R8: While `pwr_en` is 0, all measurement, reference and fault state is cleared at each clock.
- R9: Length counters saturate at 2^CNT_W-1, so two lengths that both reach that value compare as equal.
- R10: Data-enable length is the number of clocks sampled high from its rising edge to its falling edge. Vertical period is the number of clocks from one rising edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Power enable; 0 clears all state synchronously |
| self_test_en | input | 1 | 1 routes the self-test result to the status output |
| self_test_err | input | 1 | Self-test error flag from the pattern checker |
| vsync | input | 1 | Recovered vertical sync |
| den | input | 1 | Recovered data enable |
| flag_clear | input | 1 | One-clock strobe that clears a latched fault |
| timing_ok | output | 1 | 1 = no fault (or self-test passing), 0 = fault |

## Verification
The bench builds the monitor with CNT_W = 5. This puts counter saturation at 31 clocks, so data-enable windows of 40 and 50 clocks both clip to the limit and are shown to compare equal. The vertical thresholds stay at their defaults of one mismatch for data enable and two for vertical sync. Vertical periods of 10 to 16 clocks are short enough that the isolated-mismatch, counter-reset and double-mismatch sequences each take only a few hundred clocks.

// File: rtl/stm_pkg.sv
package stm_pkg;
   // How a span meter turns edges of its input into a length.
   typedef enum logic {
      MEAS_HIGH_SPAN    = 1'b0,  // clocks sampled high, rise to fall
      MEAS_RISE_TO_RISE = 1'b1   // clocks between consecutive rising edges
   } meas_mode_e;
endpackage

// File: rtl/stm_span_meter.sv
module stm_span_meter #(
   parameter int                  CNT_W = 16,
   parameter stm_pkg::meas_mode_e MODE  = stm_pkg::MEAS_HIGH_SPAN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sig,
   output logic             meas_vld,
   output logic [CNT_W-1:0] meas_len
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("stm_span_meter: CNT_W must be at least 2");
   end

   logic             sig_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             rise;

   assign rise    = sig & ~sig_q;
   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;

   if (MODE == stm_pkg::MEAS_HIGH_SPAN) begin : g_high_span
      logic fall;
      assign fall = ~sig & sig_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sig_q    <= 1'b0;
            cnt      <= '0;
            meas_vld <= 1'b0;
            meas_len <= '0;
         end else if (clr) begin
            sig_q    <= 1'b0;
            cnt      <= '0;
            meas_vld <= 1'b0;
            meas_len <= '0;
         end else begin
            sig_q    <= sig;
            meas_vld <= 1'b0;
            if (rise) begin
               cnt <= CNT_ONE;
            end else if (sig) begin
               cnt <= cnt_inc;
            end
            if (fall) begin
               meas_vld <= 1'b1;
               meas_len <= cnt;
            end
         end
      end
   end else begin : g_rise_to_rise
      logic armed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sig_q    <= 1'b0;
            cnt      <= '0;
            armed    <= 1'b0;
            meas_vld <= 1'b0;
            meas_len <= '0;
         end else if (clr) begin
            sig_q    <= 1'b0;
            cnt      <= '0;
            armed    <= 1'b0;
            meas_vld <= 1'b0;
            meas_len <= '0;
         end else begin
            sig_q    <= sig;
            meas_vld <= 1'b0;
            if (rise) begin
               armed <= 1'b1;
               cnt   <= CNT_ONE;
               if (armed) begin
                  meas_vld <= 1'b1;
                  meas_len <= cnt;
               end
            end else begin
               cnt <= cnt_inc;
            end
         end
      end
   end
endmodule

// File: rtl/stm_len_judge.sv
module stm_len_judge #(
   parameter int CNT_W = 16,
   parameter int THR   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             meas_vld,
   input  logic [CNT_W-1:0] meas_len,
   output logic             hit
);
   localparam int             MISS_W = $clog2(THR + 1);
   localparam logic [MISS_W-1:0] THR_V  = MISS_W'(THR);
   localparam logic [MISS_W-1:0] MISS_ONE = MISS_W'(1);

   if (THR < 1) begin : g_bad_thr
      $error("stm_len_judge: THR must be at least 1");
   end

   logic [CNT_W-1:0]  ref_len;
   logic              has_ref;
   logic [MISS_W-1:0] miss;
   logic [MISS_W-1:0] miss_inc;

   assign miss_inc = (miss == THR_V) ? miss : miss + MISS_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_len <= '0;
         has_ref <= 1'b0;
         miss    <= '0;
         hit     <= 1'b0;
      end else if (clr) begin
         ref_len <= '0;
         has_ref <= 1'b0;
         miss    <= '0;
         hit     <= 1'b0;
      end else begin
         hit <= 1'b0;
         if (meas_vld) begin
            ref_len <= meas_len;
            if (!has_ref) begin
               has_ref <= 1'b1;
               miss    <= '0;
            end else if (meas_len != ref_len) begin
               miss <= miss_inc;
               if (miss_inc == THR_V) begin
                  hit <= 1'b1;
               end
            end else begin
               miss <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/stm_timing_monitor.sv
module stm_timing_monitor #(
   parameter int CNT_W  = 16,
   parameter int DE_THR = 1,
   parameter int VS_THR = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic self_test_en,
   input  logic self_test_err,
   input  logic vsync,
   input  logic den,
   input  logic flag_clear,
   output logic timing_ok
);
   logic             clr;
   logic             de_vld;
   logic [CNT_W-1:0] de_len;
   logic             de_hit;
   logic             vs_vld;
   logic [CNT_W-1:0] vs_len;
   logic             vs_hit;
   logic             fault_q;

   assign clr = ~pwr_en;

   stm_span_meter #(.CNT_W(CNT_W), .MODE(stm_pkg::MEAS_HIGH_SPAN)) u_de_meter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sig(den),
      .meas_vld(de_vld), .meas_len(de_len)
   );

   stm_len_judge #(.CNT_W(CNT_W), .THR(DE_THR)) u_de_judge (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .meas_vld(de_vld), .meas_len(de_len), .hit(de_hit)
   );

   stm_span_meter #(.CNT_W(CNT_W), .MODE(stm_pkg::MEAS_RISE_TO_RISE)) u_vs_meter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sig(vsync),
      .meas_vld(vs_vld), .meas_len(vs_len)
   );

   stm_len_judge #(.CNT_W(CNT_W), .THR(VS_THR)) u_vs_judge (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .meas_vld(vs_vld), .meas_len(vs_len), .hit(vs_hit)
   );

   // A fresh fault outranks a clear arriving in the same clock.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (clr) begin
         fault_q <= 1'b0;
      end else if (de_hit || vs_hit) begin
         fault_q <= 1'b1;
      end else if (flag_clear) begin
         fault_q <= 1'b0;
      end
   end

   assign timing_ok = self_test_en ? ~self_test_err : ~fault_q;
endmodule

// File: rtl/stm_timing_monitor_chk.sv
module stm_timing_monitor_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_en,
   input logic             self_test_en,
   input logic             self_test_err,
   input logic             flag_clear,
   input logic             timing_ok,
   input logic             fault_q,
   input logic             de_hit,
   input logic             de_vld,
   input logic [CNT_W-1:0] de_len
);
   // R2
   de_hit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de_hit && pwr_en) |=> fault_q);

   // R6
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && pwr_en && !flag_clear) |=> fault_q);

   // R7
   self_test_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (self_test_en && self_test_err) |-> !timing_ok);

   // R8
   pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> !fault_q);

   // R10
   de_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de_vld |-> (de_len != '0));
endmodule

bind stm_timing_monitor stm_timing_monitor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .self_test_en(self_test_en),
   .self_test_err(self_test_err), .flag_clear(flag_clear), .timing_ok(timing_ok),
   .fault_q(fault_q), .de_hit(de_hit), .de_vld(de_vld), .de_len(de_len)
);

// File: tb/stm_timing_monitor_tb.sv
module stm_timing_monitor_tb;
   localparam int CNT_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_en = 1'b1;
   logic self_test_en = 1'b0;
   logic self_test_err = 1'b0;
   logic vsync = 1'b0;
   logic den = 1'b0;
   logic flag_clear = 1'b0;
   logic timing_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stm_timing_monitor #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .self_test_en(self_test_en),
      .self_test_err(self_test_err), .vsync(vsync), .den(den),
      .flag_clear(flag_clear), .timing_ok(timing_ok)
   );

   typedef struct packed {
      logic clr_first;
      int   len;
      logic exp_ok;
   } vec_t;

   localparam int NV = 10;
   // DE windows; R5 first loads ref, R2 mismatches, R6 clears, R10 lengths
   localparam vec_t VECS [NV] = '{
      '{1'b0, 5, 1'b1},
      '{1'b0, 5, 1'b1},
      '{1'b0, 6, 1'b0},
      '{1'b1, 6, 1'b1},
      '{1'b0, 6, 1'b1},
      '{1'b0, 3, 1'b0},
      '{1'b1, 4, 1'b0},
      '{1'b1, 4, 1'b1},
      '{1'b1, 1, 1'b0},
      '{1'b1, 1, 1'b1}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: timing_ok=%b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      den = 1'b0; vsync = 1'b0; flag_clear = 1'b0;
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic de_burst(input int len);
      den = 1'b1;
      tick(len);
      den = 1'b0;
      tick(6);
   endtask

   task automatic pulse_clear();
      flag_clear = 1'b1;
      tick(1);
      flag_clear = 1'b0;
      tick(1);
   endtask

   task automatic vs_frame(input int p);
      vsync = 1'b1;
      tick(2);
      vsync = 1'b0;
      tick(p - 2);
   endtask

   initial begin
      tick(2);
      do_reset();
      check("R1 reset state", timing_ok, 1'b1);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].clr_first) pulse_clear();
         de_burst(VECS[i].len);
         check($sformatf("R2/R5/R6/R10 vector %0d", i), timing_ok, VECS[i].exp_ok);
      end

      // fault then hold without clear (R6)
      de_burst(2);
      check("R2 DE 2 after 1", timing_ok, 1'b0);
      tick(20);
      check("R6 fault stays latched", timing_ok, 1'b0);

      // self-test routing (R7)
      self_test_en = 1'b1; self_test_err = 1'b0;
      tick(1);
      check("R7 self-test pass over fault", timing_ok, 1'b1);
      self_test_err = 1'b1;
      tick(1);
      check("R7 self-test error", timing_ok, 1'b0);
      self_test_en = 1'b0; self_test_err = 1'b0;
      tick(1);
      check("R7 back to timing state", timing_ok, 1'b0);

      // power-down clears everything (R8), first measurement reloads (R5)
      pwr_en = 1'b0;
      tick(2);
      pwr_en = 1'b1;
      tick(1);
      check("R8 power-down clears fault", timing_ok, 1'b1);
      de_burst(9);
      check("R5 first DE after power-down loads only", timing_ok, 1'b1);
      de_burst(9);
      check("R2 matching DE", timing_ok, 1'b1);
      de_burst(8);
      check("R2 DE 8 after 9", timing_ok, 1'b0);
      pulse_clear();
      check("R6 clear strobe releases", timing_ok, 1'b1);

      // saturation (R9): limit 31
      do_reset();
      de_burst(40);
      de_burst(50);
      check("R9 saturated lengths compare equal", timing_ok, 1'b1);
      de_burst(10);
      check("R9 below limit still mismatches", timing_ok, 0);

      // vertical sync consecutive rule (R3, R4)
      do_reset();
      vs_frame(10);
      vs_frame(10);
      vs_frame(12);
      vs_frame(12);
      check("R3 single VS mismatch ignored", timing_ok, 1'b1);
      vs_frame(12);
      vs_frame(14);
      check("R4 match resets VS count", timing_ok, 1'b1);
      vs_frame(16);
      check("R4 mismatch after match stays ok", timing_ok, 1'b1);
      vs_frame(10);
      check("R3 two VS mismatches in a row", timing_ok, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule